// File: doc/BRIEF.md
# SCL Clock Generator

This block produces the clock line of a two-wire serial bus master. A free-running prescaler divides the system clock by a programmable amount to make a tick. The low and high halves of each SCL period are timed separately in those ticks, in one of three low-to-high ratios. The block drives SCL only in open-drain fashion: it either pulls the line low or lets it go.

The high half is not counted until the block sees SCL actually high on its sampled input. A slave that keeps the line low therefore stretches the period. Other bus logic uses the tick strobe and the two edge strobes to line its own work up with the clock. That logic is not part of this block: it does not generate START or STOP conditions, shift data or arbitrate.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted, `sclDriveLow`, `tickStb`, `sclFallStb` and `sclRiseStb` are all 0.
- R2: While `enable` is 1, `tickStb` is a one-cycle pulse that repeats every `divVal`+1 system clocks. With `divVal` = 0 it is high on every enabled cycle.
- R3: With `ratioSel` = 0 and `divVal` = D ≥ 1, an SCL period that is not stretched lasts 4·(D+1) clocks low and 4·(D+1) clocks released.
- R4: With `ratioSel` = 1 the low time is 6·(D+1) clocks and the high time is 3·(D+1) clocks.
- R5: With `ratioSel` = 2 the low time is 11·(D+1) clocks and the high time is 6·(D+1) clocks.
- R6: `ratioSel` = 3 is reserved and gives the same timing as `ratioSel` = 0.
- R7: While `sclIn` stays low after the block has released SCL, the block keeps SCL released and raises no rise strobe. High-phase counting starts only in the cycle after `sclIn` is first seen high. The low drive then returns between (Nhigh−1)·(D+1)+1 and Nhigh·(D+1) clocks after the rise strobe.
- R8: One clock after `enable` goes to 0, SCL is released and all three strobes are 0. They stay that way while `enable` is 0.
- R9: `sclFallStb` is high for exactly one cycle, the first cycle in which `sclDriveLow` is 1.
- R10: `sclRiseStb` is high for one cycle, one clock after `sclIn` is first seen high in a released phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator; 0 releases SCL and stops the prescaler |
| divVal | input | DIV_W (9) | Prescaler divide value; one tick per divVal+1 clocks |
| ratioSel | input | 2 | Low:high ratio select: 0 = 4:4, 1 = 6:3, 2 = 11:6, 3 = as 0 |
| sclIn | input | 1 | Sampled, already synchronised SCL line level |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| tickStb | output | 1 | Prescaled tick strobe |
| sclRiseStb | output | 1 | SCL seen high after release |
| sclFallStb | output | 1 | Block started to pull SCL low |

## Verification
Every output comes from a register, so a change of input or tick takes effect at the next rising edge and shows at the following falling edge. A phase ends on the edge after its last counted tick. The rise strobe appears one edge after `sclIn` goes high, and counting starts on the edge after that. The bench drives inputs and samples outputs on falling edges, and a cycle model advances on rising edges and is compared at every falling edge. Period lengths are measured from the second period after a setting changes, because the tick phase of the first period is not aligned with it.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  localparam int PH_CNT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // strobes from control to the phase counter in the datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cnt_ctrl_t;

  function automatic logic [PH_CNT_W-1:0] lowTicks(input logic [1:0] sel);
    case (sel)
      2'd1:    lowTicks = PH_CNT_W'(6);
      2'd2:    lowTicks = PH_CNT_W'(11);
      default: lowTicks = PH_CNT_W'(4);
    endcase
  endfunction

  function automatic logic [PH_CNT_W-1:0] highTicks(input logic [1:0] sel);
    case (sel)
      2'd1:    highTicks = PH_CNT_W'(3);
      2'd2:    highTicks = PH_CNT_W'(6);
      default: highTicks = PH_CNT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/sclgen_datapath.sv
module sclgen_datapath
  import sclgen_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int CNT_W = PH_CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divVal,
  input  logic [1:0]       ratioSel,
  input  cnt_ctrl_t        ctrl,
  output logic             tickStb,
  output logic             lowDone,
  output logic             highDone
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [DIV_W-1:0] preCnt;
  logic [CNT_W-1:0] phaseCnt;

  // prescaler: one tick per divVal+1 clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickStb <= 1'b0;
    end else if (!enable) begin
      preCnt  <= '0;
      tickStb <= 1'b0;
    end else if (preCnt >= divVal) begin
      preCnt  <= '0;
      tickStb <= 1'b1;
    end else begin
      preCnt  <= preCnt + DIV_W'(1);
      tickStb <= 1'b0;
    end
  end

  // phase tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (!enable || ctrl.cntClr) begin
      phaseCnt <= '0;
    end else if (ctrl.cntInc) begin
      phaseCnt <= phaseCnt + ONE;
    end
  end

  // compare with >= so a ratio change mid-phase cannot overrun
  assign lowDone  = phaseCnt >= (CNT_W'(lowTicks(ratioSel))  - ONE);
  assign highDone = phaseCnt >= (CNT_W'(highTicks(ratioSel)) - ONE);

endmodule

// File: rtl/sclgen_control.sv
module sclgen_control
  import sclgen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      tickStb,
  input  logic      lowDone,
  input  logic      highDone,
  input  logic      sclIn,
  output cnt_ctrl_t ctrl,
  output logic      drvLow,
  output logic      fallStb,
  output logic      riseStb
);

  phase_e phase;
  logic   seenHigh;

  always_comb begin
    ctrl = '0;
    case (phase)
      PH_LOW: begin
        if (tickStb) begin
          ctrl.cntClr = lowDone;
          ctrl.cntInc = !lowDone;
        end
      end
      PH_HIGH: begin
        if (seenHigh && tickStb) begin
          ctrl.cntClr = highDone;
          ctrl.cntInc = !highDone;
        end
      end
      default: ctrl.cntClr = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      seenHigh <= 1'b0;
      drvLow   <= 1'b0;
      fallStb  <= 1'b0;
      riseStb  <= 1'b0;
    end else if (!enable) begin
      phase    <= PH_IDLE;
      seenHigh <= 1'b0;
      drvLow   <= 1'b0;
      fallStb  <= 1'b0;
      riseStb  <= 1'b0;
    end else begin
      fallStb <= 1'b0;
      riseStb <= 1'b0;
      case (phase)
        PH_IDLE: begin
          phase   <= PH_LOW;
          drvLow  <= 1'b1;
          fallStb <= 1'b1;
        end
        PH_LOW: begin
          if (tickStb && lowDone) begin
            phase    <= PH_HIGH;
            drvLow   <= 1'b0;
            seenHigh <= 1'b0;
          end
        end
        PH_HIGH: begin
          riseStb <= sclIn && !seenHigh;
          if (sclIn) seenHigh <= 1'b1;
          if (seenHigh && tickStb && highDone) begin
            phase   <= PH_LOW;
            drvLow  <= 1'b1;
            fallStb <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import sclgen_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divVal,
  input  logic [1:0]       ratioSel,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             tickStb,
  output logic             sclRiseStb,
  output logic             sclFallStb
);

  cnt_ctrl_t ctrl;
  logic      lowDone;
  logic      highDone;

  sclgen_datapath #(.DIV_W(DIV_W), .CNT_W(PH_CNT_W)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .divVal   (divVal),
    .ratioSel (ratioSel),
    .ctrl     (ctrl),
    .tickStb  (tickStb),
    .lowDone  (lowDone),
    .highDone (highDone)
  );

  sclgen_control ctl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .tickStb  (tickStb),
    .lowDone  (lowDone),
    .highDone (highDone),
    .sclIn    (sclIn),
    .ctrl     (ctrl),
    .drvLow   (sclDriveLow),
    .fallStb  (sclFallStb),
    .riseStb  (sclRiseStb)
  );

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk #(
  parameter int DIV_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [DIV_W-1:0] divVal,
  input logic             sclIn,
  input logic             sclDriveLow,
  input logic             tickStb,
  input logic             sclRiseStb,
  input logic             sclFallStb
);

  AST_FALL_STARTS_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    sclFallStb |-> (sclDriveLow && !$past(sclDriveLow))); // R9

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sclFallStb |=> !sclFallStb); // R9

  AST_RISE_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    sclRiseStb |-> !sclDriveLow); // R10

  AST_RISE_NEEDS_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclRiseStb |-> $past(sclIn)); // R7

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !tickStb && !sclFallStb && !sclRiseStb)); // R8

  AST_TICK_DIV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && ($past(divVal) == '0)) |-> tickStb); // R2

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!sclDriveLow && !tickStb && !sclFallStb && !sclRiseStb); // R1
    end
  end

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.DIV_W(DIV_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .divVal      (divVal),
  .sclIn       (sclIn),
  .sclDriveLow (sclDriveLow),
  .tickStb     (tickStb),
  .sclRiseStb  (sclRiseStb),
  .sclFallStb  (sclFallStb)
);

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [8:0] divVal = '0;
  logic [1:0] ratioSel = '0;
  logic       slaveHold = 1'b0;
  logic       sclIn;
  logic       sclDriveLow, tickStb, sclRiseStb, sclFallStb;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R3";

  // open-drain bus: high unless the block or a slave pulls it low
  assign sclIn = !sclDriveLow && !slaveHold;

  scl_clock_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divVal(divVal),
    .ratioSel(ratioSel), .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .tickStb(tickStb), .sclRiseStb(sclRiseStb), .sclFallStb(sclFallStb)
  );

  always #4 clk = !clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  int  mPre = 0, mCnt = 0, mPh = 0;
  bit  mTick = 0, mSeen = 0, mDrv = 0, mFall = 0, mRise = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mPh = 0;
      mTick = 0; mSeen = 0; mDrv = 0; mFall = 0; mRise = 0;
    end else begin
      bit lineHigh, oldTick, oldSeen;
      int nl, nh;
      lineHigh = !mDrv && !slaveHold;
      oldTick  = mTick;
      nl = (ratioSel == 2'd1) ? 6 : (ratioSel == 2'd2) ? 11 : 4;
      nh = (ratioSel == 2'd1) ? 3 : (ratioSel == 2'd2) ? 6 : 4;
      if (!enable) begin
        mPre = 0; mTick = 0;
      end else if (mPre >= int'(divVal)) begin
        mPre = 0; mTick = 1;
      end else begin
        mPre++; mTick = 0;
      end
      if (!enable) begin
        mPh = 0; mCnt = 0; mSeen = 0; mDrv = 0; mFall = 0; mRise = 0;
      end else if (mPh == 0) begin
        mPh = 1; mCnt = 0; mDrv = 1; mFall = 1; mRise = 0;
      end else if (mPh == 1) begin
        mFall = 0; mRise = 0;
        if (oldTick) begin
          if (mCnt >= nl - 1) begin
            mPh = 2; mCnt = 0; mDrv = 0; mSeen = 0;
          end else mCnt++;
        end
      end else begin
        mFall = 0;
        mRise = lineHigh && !mSeen;
        oldSeen = mSeen;
        if (lineHigh) mSeen = 1;
        if (oldSeen && oldTick) begin
          if (mCnt >= nh - 1) begin
            mPh = 1; mDrv = 1; mFall = 1; mCnt = 0;
          end else mCnt++;
        end
      end
    end
  end

  // compare with the model on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(sclDriveLow == mDrv, curReq, sclDriveLow, mDrv);
      check(tickStb == mTick, "R2", tickStb, mTick);
      check(sclFallStb == mFall, "R9", sclFallStb, mFall);
      check(sclRiseStb == mRise, "R10", sclRiseStb, mRise);
    end
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic measure(output int lowLen, output int highLen);
    while (!sclFallStb) @(negedge clk);
    lowLen = 0;
    while (sclDriveLow) begin lowLen++; @(negedge clk); end
    highLen = 0;
    while (!sclDriveLow) begin highLen++; @(negedge clk); end
  endtask

  task automatic runRatio(input logic [1:0] sel, input int d, input int nl, input int nh, input string req);
    int lo, hi;
    curReq = req;
    ratioSel = sel;
    divVal = 9'(d);
    measure(lo, hi);
    measure(lo, hi);
    check(lo == nl * (d + 1), req, lo, nl * (d + 1));
    check(hi == nh * (d + 1), req, hi, nh * (d + 1));
  endtask

  initial begin
    int gap, ticks, k;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!sclDriveLow && !tickStb && !sclFallStb && !sclRiseStb, "R1",
          {sclDriveLow, tickStb, sclFallStb, sclRiseStb}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: tick period with divVal = 5
    divVal = 9'd5;
    enable = 1'b1;
    while (!tickStb) @(negedge clk);
    gap = 0;
    do begin gap++; @(negedge clk); end while (!tickStb);
    check(gap == 6, "R2", gap, 6);

    runRatio(2'd0, 1, 4, 4, "R3");
    runRatio(2'd0, 3, 4, 4, "R3");
    runRatio(2'd1, 1, 6, 3, "R4");
    runRatio(2'd2, 2, 11, 6, "R5");
    runRatio(2'd3, 1, 4, 4, "R6");

    // R2: divVal = 0 ticks every cycle (model compares each cycle)
    curReq = "R2";
    divVal = 9'd0;
    repeat (60) @(negedge clk);

    // R8: disable while driving low
    curReq = "R8";
    divVal = 9'd1;
    ratioSel = 2'd0;
    while (!sclDriveLow) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!sclDriveLow && !tickStb && !sclFallStb && !sclRiseStb, "R8",
          {sclDriveLow, tickStb, sclFallStb, sclRiseStb}, 0);
    ticks = 0;
    repeat (20) begin
      @(negedge clk);
      if (tickStb || sclDriveLow || sclFallStb || sclRiseStb) ticks++;
    end
    check(ticks == 0, "R8", ticks, 0);

    // R7 / R10: slave stretches the high phase
    curReq = "R7";
    enable = 1'b1;
    begin
      int lo, hi;
      measure(lo, hi);
    end
    while (!sclFallStb) @(negedge clk);
    slaveHold = 1'b1;
    while (sclDriveLow) @(negedge clk);
    ticks = 0;
    repeat (10) begin
      if (sclRiseStb || sclDriveLow) ticks++;
      @(negedge clk);
    end
    check(ticks == 0, "R7", ticks, 0);
    slaveHold = 1'b0;
    @(negedge clk);
    check(sclRiseStb == 1'b1, "R10", sclRiseStb, 1);
    k = 0;
    do begin k++; @(negedge clk); end while (!sclDriveLow);
    check(k >= 7 && k <= 8, "R7", k, 8);
    check(sclFallStb == 1'b1, "R9", sclFallStb, 1);
    @(negedge clk);
    check(sclFallStb == 1'b0, "R9", sclFallStb, 0);

    repeat (40) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule